// File: doc/BRIEF.md
# Resonant Period Bin Sequencer

This block splits each drive period of a resonant actuator into sixteen equal-time bins, eight per half-cycle. It works from a 125 kHz tick enable and a programmable half-period length counted in those ticks. From the bin position it produces three things:

- the drive square wave;
- interrupt requests at a programmed bin, with an optional divider in whole periods;
- one 16-bit sample per bin, written into a sixteen-entry sample bank.

Each sample is taken from one of four candidate signals. It is either the last value seen in the bin or the average of all values seen in the bin.

Control fields arrive as plain input ports, and the bank and the bin index are plain outputs. The current bin index is exposed so that software can compare it with the interrupt index around a change of the half-period length. The analog bridge, the converter and any bus access sit outside the block.

Top module: `resonant_bin_seq`

## Requirements
- R1: After reset the bin index is 0, the interrupt output is low and every sample bank entry is zero.
- R2: The half-period of P ticks is divided into 8 bins. Each bin lasts P/8 ticks (integer division), except bins 7 and 15, which last P - 7*(P/8) ticks. On the last tick of a bin the index advances by one, and it wraps from 15 to 0.
- R3: A half-period length below 8 behaves exactly as a length of 8, so every bin lasts one tick.
- R4: With the polarity input at 0, the wave output is 0 during bins 0-7 and 1 during bins 8-15. With polarity at 1 the wave output is inverted in the same clock cycle.
- R5: The interrupt output is a one-cycle pulse in the cycle after the last tick of the matching bin. For an interrupt index i below 8 the matching bins are i and i+8. For i of 8 or more the only matching bin is i.
- R6: A divider value of 0 or 1 allows interrupts in every period. A value N of 2 or more allows them only in the first of every N periods, counted from the moment the controller is enabled.
- R7: With the interrupt enable input low, no interrupt pulse is produced.
- R8: While the controller enable is low, the bin index is held at 0, ticks are ignored, the in-bin accumulation is cleared and the period counter of the divider returns to zero.
- R9: The sample select input picks the captured signal: 0 the down-sampled sense value, 1 the error value, 2 the filtered duty, 3 the duty after the reference is added.
- R10: With sample mode 1, bank entry b receives the selected value present on the last tick of bin b.
- R11: With sample mode 0, bank entry b receives the signed sum of the selected values over all ticks of bin b, divided by the tick count and truncated toward zero. The entry is written no later than 40 clock cycles after that last tick.
- R12: Bank entry b occupies bits [16*b+15 : 16*b] of the sample bank output. Values are two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle 125 kHz tick enable |
| ctrl_en | input | 1 | Controller enable |
| half_period | input | 16 | Half-period length in ticks |
| polarity | input | 1 | Inverts the wave output |
| irq_en | input | 1 | Interrupt enable |
| irq_idx | input | 4 | Bin index at which interrupts fire |
| irq_div | input | 4 | Interrupt divider in whole periods |
| smp_mode | input | 1 | 0 = bin average, 1 = last value in bin |
| smp_sel | input | 2 | Captured signal select |
| src_sense | input | 16 | Down-sampled sense value |
| src_error | input | 16 | Error value |
| src_duty_flt | input | 16 | Filtered duty |
| src_duty_ref | input | 16 | Duty plus reference |
| wave_out | output | 1 | Drive square wave |
| bin_idx | output | 4 | Current bin index |
| irq_pulse | output | 1 | Interrupt request pulse |
| smp_bank | output | 256 | Sixteen 16-bit sample entries |

## Verification
A tick counter or bin index that has drifted shows up on the bin index and wave outputs within the bin where the error happens. It also moves the interrupt pulse to a different bin or to a different period of the divider sequence. An accumulator or divider fault does not show up straight away: it only becomes visible once the bin closes and its bank entry is written, within about forty cycles. Because of this, every bank entry is compared after a full period, for several select values, for both sample modes and for bin lengths that do and do not divide evenly.

// File: rtl/rbs_pkg.sv
// Shared types for the resonant period bin sequencer.
package rbs_pkg;

    // Captured signal select encoding.
    typedef enum logic [1:0] {
        SRC_SENSE    = 2'd0,
        SRC_ERROR    = 2'd1,
        SRC_DUTY_FLT = 2'd2,
        SRC_DUTY_REF = 2'd3
    } src_sel_e;

endpackage

// File: rtl/rbs_bin_timer.sv
// Bin timer: counts ticks inside the current bin and steps the bin index.
// Assumes HALF_BINS is a power of two. Half-period values below HALF_BINS
// are raised to HALF_BINS. The remainder of the division goes into the
// last bin of each half-cycle.
module rbs_bin_timer #(
    parameter int TICK_W    = 16,
    parameter int HALF_BINS = 8,
    localparam int BIN_W    = $clog2(2 * HALF_BINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic              tick_en,
    input  logic [TICK_W-1:0] half_period,
    output logic [BIN_W-1:0]  bin_idx,
    output logic              bin_end
);
    localparam int SH = $clog2(HALF_BINS);
    localparam logic [TICK_W-1:0] HB      = TICK_W'(HALF_BINS);
    localparam logic [TICK_W-1:0] HB_M1   = TICK_W'(HALF_BINS - 1);

    logic [TICK_W-1:0] tick_cnt;
    logic [TICK_W-1:0] eff_hp;
    logic [TICK_W-1:0] base_len;
    logic [TICK_W-1:0] last_len;
    logic [TICK_W-1:0] cur_len;
    logic              is_last;

    // Effective half-period and the length of the current bin.
    always_comb begin
        eff_hp   = (half_period < HB) ? HB : half_period;
        base_len = eff_hp >> SH;
        last_len = eff_hp - base_len * HB_M1;
        is_last  = &bin_idx[SH-1:0];
        cur_len  = is_last ? last_len : base_len;
    end

    // The final tick of a bin; ">=" covers a length that shrinks mid-bin.
    assign bin_end = tick_en && ctrl_en && (tick_cnt >= cur_len - 1'b1);

    // Tick counter and bin index.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_en) begin
            tick_cnt <= '0;
            bin_idx  <= '0;
        end else if (bin_end) begin
            tick_cnt <= '0;
            bin_idx  <= bin_idx + 1'b1;
        end else if (tick_en) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rbs_irq_gen.sv
// Interrupt generator: raises a one-cycle pulse on the closing tick of the
// programmed bin. Low indexes match in both half-cycles, high indexes only
// in the second. A whole-period divider gates which periods may fire.
module rbs_irq_gen #(
    parameter int BIN_W = 4,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_en,
    input  logic             irq_en,
    input  logic [BIN_W-1:0] irq_idx,
    input  logic [DIV_W-1:0] irq_div,
    input  logic             bin_end,
    input  logic [BIN_W-1:0] bin_idx,
    output logic             irq_pulse
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] per_cnt;
    logic             period_end;
    logic             hit;
    logic             fire_ok;
    logic             every;

    // Bin match with the dual-half-cycle rule, and the divider gate.
    always_comb begin
        period_end = bin_end && (&bin_idx);
        if (irq_idx[BIN_W-1])
            hit = (bin_idx == irq_idx);
        else
            hit = (bin_idx[BIN_W-2:0] == irq_idx[BIN_W-2:0]);
        every   = (irq_div <= ONE);
        fire_ok = every || (per_cnt == '0);
    end

    // Period counter for the divider; restarts when the controller is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_en)
            per_cnt <= '0;
        else if (period_end)
            per_cnt <= (every || per_cnt >= irq_div - ONE) ? '0 : per_cnt + ONE;
    end

    // Registered single-cycle interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_pulse <= 1'b0;
        else
            irq_pulse <= irq_en && bin_end && hit && fire_ok;
    end

endmodule

// File: rtl/rbs_sample_acc.sv
// Sample accumulator: selects one of four signals and sums it over the
// ticks of a bin. The totals it presents include the value on the current
// tick, so on the closing tick they cover the whole bin.
module rbs_sample_acc
    import rbs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TICK_W = 16,
    localparam int SUM_W = DATA_W + TICK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic              tick_en,
    input  logic              bin_end,
    input  logic [1:0]        smp_sel,
    input  logic [DATA_W-1:0] src_sense,
    input  logic [DATA_W-1:0] src_error,
    input  logic [DATA_W-1:0] src_duty_flt,
    input  logic [DATA_W-1:0] src_duty_ref,
    output logic [DATA_W-1:0] cur_val,
    output logic [SUM_W-1:0]  tot_sum,
    output logic [TICK_W-1:0] tot_cnt
);
    logic [SUM_W-1:0]  acc_sum;
    logic [TICK_W-1:0] acc_cnt;
    logic [SUM_W-1:0]  cur_ext;
    src_sel_e          sel;

    // Select the captured signal.
    always_comb begin
        sel = src_sel_e'(smp_sel);
        case (sel)
            SRC_SENSE:    cur_val = src_sense;
            SRC_ERROR:    cur_val = src_error;
            SRC_DUTY_FLT: cur_val = src_duty_flt;
            default:      cur_val = src_duty_ref;
        endcase
        cur_ext = {{TICK_W{cur_val[DATA_W-1]}}, cur_val};
        tot_sum = acc_sum + cur_ext;
        tot_cnt = acc_cnt + 1'b1;
    end

    // Running sum and tick count of the open bin.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_en || bin_end) begin
            acc_sum <= '0;
            acc_cnt <= '0;
        end else if (tick_en) begin
            acc_sum <= tot_sum;
            acc_cnt <= tot_cnt;
        end
    end

endmodule

// File: rtl/rbs_avg_div.sv
// Serial signed divider for bin averages: one quotient bit per clock,
// restoring on the magnitude, sign restored at the end, truncating toward
// zero. Assumes the next start comes at least SUM_W+2 clocks later.
module rbs_avg_div #(
    parameter int SUM_W  = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SUM_W-1:0]  dividend,
    input  logic [CNT_W-1:0]  divisor,
    input  logic [IDX_W-1:0]  start_idx,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] quotient,
    output logic [IDX_W-1:0]  done_idx
);
    localparam int STEP_W = $clog2(SUM_W + 1);

    logic [SUM_W-1:0]  q;
    logic [CNT_W:0]    rem;
    logic [CNT_W:0]    rem_sh;
    logic [CNT_W-1:0]  dvs;
    logic [STEP_W-1:0] steps;
    logic              neg;
    logic [DATA_W-1:0] q_mag;

    // Shifted remainder for this step.
    assign rem_sh = {rem[CNT_W-1:0], q[SUM_W-1]};
    assign q_mag  = q[DATA_W-1:0];

    // Load, iterate and complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            rem      <= '0;
            dvs      <= '0;
            steps    <= '0;
            neg      <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            done_idx <= '0;
        end else if (start) begin
            neg      <= dividend[SUM_W-1];
            q        <= dividend[SUM_W-1] ? (~dividend + 1'b1) : dividend;
            rem      <= '0;
            dvs      <= divisor;
            steps    <= STEP_W'(SUM_W);
            busy     <= 1'b1;
            done     <= 1'b0;
            done_idx <= start_idx;
        end else if (busy) begin
            if (rem_sh >= {1'b0, dvs}) begin
                rem <= rem_sh - {1'b0, dvs};
                q   <= {q[SUM_W-2:0], 1'b1};
            end else begin
                rem <= rem_sh;
                q   <= {q[SUM_W-2:0], 1'b0};
            end
            steps <= steps - 1'b1;
            busy  <= (steps != STEP_W'(1));
            done  <= (steps == STEP_W'(1));
        end else begin
            done <= 1'b0;
        end
    end

    // Signed result.
    assign quotient = neg ? (~q_mag + 1'b1) : q_mag;

endmodule

// File: rtl/rbs_sample_bank.sv
// Sample bank: one register per bin, written through a single port and
// presented as a flat vector with entry b at bits [DATA_W*b +: DATA_W].
module rbs_sample_bank #(
    parameter int NUM_BINS = 16,
    parameter int DATA_W   = 16,
    localparam int BIN_W   = $clog2(NUM_BINS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [BIN_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_BINS*DATA_W-1:0] bank
);
    for (genvar g = 0; g < NUM_BINS; g++) begin : g_entry
        // Hold one bin's sample until that bin is written again.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank[g*DATA_W +: DATA_W] <= '0;
            else if (wr_en && wr_idx == BIN_W'(g))
                bank[g*DATA_W +: DATA_W] <= wr_data;
        end
    end

endmodule

// File: rtl/resonant_bin_seq.sv
// Resonant period bin sequencer top. Divides each drive period into
// 2*HALF_BINS bins driven by a tick enable, produces the square wave and
// interrupt pulses, and captures one sample per bin. Assumes tick_en is a
// single-cycle pulse with at least DATA_W+TICK_W+2 clocks between ticks.
module resonant_bin_seq #(
    parameter int TICK_W    = 16,
    parameter int DATA_W    = 16,
    parameter int DIV_W     = 4,
    parameter int HALF_BINS = 8,
    localparam int NUM_BINS = 2 * HALF_BINS,
    localparam int BIN_W    = $clog2(NUM_BINS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_en,
    input  logic                       ctrl_en,
    input  logic [TICK_W-1:0]          half_period,
    input  logic                       polarity,
    input  logic                       irq_en,
    input  logic [BIN_W-1:0]           irq_idx,
    input  logic [DIV_W-1:0]           irq_div,
    input  logic                       smp_mode,
    input  logic [1:0]                 smp_sel,
    input  logic [DATA_W-1:0]          src_sense,
    input  logic [DATA_W-1:0]          src_error,
    input  logic [DATA_W-1:0]          src_duty_flt,
    input  logic [DATA_W-1:0]          src_duty_ref,
    output logic                       wave_out,
    output logic [BIN_W-1:0]           bin_idx,
    output logic                       irq_pulse,
    output logic [NUM_BINS*DATA_W-1:0] smp_bank
);
    localparam int SUM_W = DATA_W + TICK_W;

    logic              bin_end;
    logic [DATA_W-1:0] cur_val;
    logic [SUM_W-1:0]  tot_sum;
    logic [TICK_W-1:0] tot_cnt;
    logic              div_busy;
    logic              div_done;
    logic [DATA_W-1:0] div_q;
    logic [BIN_W-1:0]  div_idx;
    logic              direct_wr;
    logic              wr_en;
    logic [BIN_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;

    rbs_bin_timer #(.TICK_W(TICK_W), .HALF_BINS(HALF_BINS)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_en     (ctrl_en),
        .tick_en     (tick_en),
        .half_period (half_period),
        .bin_idx     (bin_idx),
        .bin_end     (bin_end)
    );

    rbs_irq_gen #(.BIN_W(BIN_W), .DIV_W(DIV_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_en   (ctrl_en),
        .irq_en    (irq_en),
        .irq_idx   (irq_idx),
        .irq_div   (irq_div),
        .bin_end   (bin_end),
        .bin_idx   (bin_idx),
        .irq_pulse (irq_pulse)
    );

    rbs_sample_acc #(.DATA_W(DATA_W), .TICK_W(TICK_W)) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_en      (ctrl_en),
        .tick_en      (tick_en),
        .bin_end      (bin_end),
        .smp_sel      (smp_sel),
        .src_sense    (src_sense),
        .src_error    (src_error),
        .src_duty_flt (src_duty_flt),
        .src_duty_ref (src_duty_ref),
        .cur_val      (cur_val),
        .tot_sum      (tot_sum),
        .tot_cnt      (tot_cnt)
    );

    rbs_avg_div #(.SUM_W(SUM_W), .CNT_W(TICK_W), .DATA_W(DATA_W), .IDX_W(BIN_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (bin_end && !smp_mode),
        .dividend  (tot_sum),
        .divisor   (tot_cnt),
        .start_idx (bin_idx),
        .busy      (div_busy),
        .done      (div_done),
        .quotient  (div_q),
        .done_idx  (div_idx)
    );

    // Bank write port: divider results first, else direct last-value writes.
    always_comb begin
        direct_wr = bin_end && smp_mode;
        wr_en     = direct_wr || div_done;
        wr_idx    = div_done ? div_idx : bin_idx;
        wr_data   = div_done ? div_q : cur_val;
    end

    rbs_sample_bank #(.NUM_BINS(NUM_BINS), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .bank    (smp_bank)
    );

    // Square wave from the half-cycle bit, polarity applied combinationally.
    assign wave_out = bin_idx[BIN_W-1] ^ polarity;

endmodule

// File: rtl/rbs_checker.sv
// Temporal checks for the bin sequencer, attached to the top by bind.
module rbs_checker #(
    parameter int BIN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_en,
    input logic             tick_en,
    input logic             irq_en,
    input logic [BIN_W-1:0] irq_idx,
    input logic [BIN_W-1:0] bin_idx,
    input logic             irq_pulse,
    input logic             bin_end,
    input logic             div_busy,
    input logic             smp_mode
);
    p_idle_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> (bin_idx == '0 && !irq_pulse));

    p_step_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bin_idx) |-> ($past(tick_en) || !$past(ctrl_en)));

    p_step_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_en) && !$stable(bin_idx)) |-> (bin_idx == BIN_W'($past(bin_idx) + 1'b1)));

    p_irq_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    p_irq_bin_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ($past(bin_idx[BIN_W-2:0]) == $past(irq_idx[BIN_W-2:0]) && $past(tick_en)));

    p_irq_late_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && $past(irq_idx[BIN_W-1])) |-> $past(bin_idx[BIN_W-1]));

    p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(irq_en));

    p_div_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bin_end && !smp_mode) |-> !div_busy);

endmodule

bind resonant_bin_seq rbs_checker #(.BIN_W(BIN_W)) u_rbs_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_en   (ctrl_en),
    .tick_en   (tick_en),
    .irq_en    (irq_en),
    .irq_idx   (irq_idx),
    .bin_idx   (bin_idx),
    .irq_pulse (irq_pulse),
    .bin_end   (bin_end),
    .div_busy  (div_busy),
    .smp_mode  (smp_mode)
);

// File: tb/resonant_bin_seq_bench.sv
// Directed bench for the resonant period bin sequencer.
module resonant_bin_seq_bench;
    localparam int TICK_GAP = 50;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         ctrl_en = 1'b0;
    logic [15:0]  half_period = 16'd8;
    logic         polarity = 1'b0;
    logic         irq_en = 1'b0;
    logic [3:0]   irq_idx = 4'd0;
    logic [3:0]   irq_div = 4'd0;
    logic         smp_mode = 1'b1;
    logic [1:0]   smp_sel = 2'd0;
    logic [15:0]  src_sense = '0;
    logic [15:0]  src_error = '0;
    logic [15:0]  src_duty_flt = '0;
    logic [15:0]  src_duty_ref = '0;
    logic         wave_out;
    logic [3:0]   bin_idx;
    logic         irq_pulse;
    logic [255:0] smp_bank;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int irq_cnt = 0;
    int last_irq_bin = -1;
    int model_hp = 8;
    int exp_bin = 0;
    int exp_tc = 0;

    resonant_bin_seq u_resonant_bin_seq (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl_en(ctrl_en),
        .half_period(half_period), .polarity(polarity), .irq_en(irq_en),
        .irq_idx(irq_idx), .irq_div(irq_div), .smp_mode(smp_mode),
        .smp_sel(smp_sel), .src_sense(src_sense), .src_error(src_error),
        .src_duty_flt(src_duty_flt), .src_duty_ref(src_duty_ref),
        .wave_out(wave_out), .bin_idx(bin_idx), .irq_pulse(irq_pulse),
        .smp_bank(smp_bank)
    );

    always #5 clk = ~clk;

    // Watchdog: an overlong run is a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors + 1, fails + 1);
            $finish;
        end
    end

    // Interrupt monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (irq_pulse) begin
            irq_cnt <= irq_cnt + 1;
            last_irq_bin <= int'(bin_idx);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int blen(input int b);
        int base;
        base = model_hp / 8;
        return (b % 8 == 7) ? model_hp - 7 * base : base;
    endfunction

    task automatic model_tick();
        exp_tc++;
        if (exp_tc == blen(exp_bin)) begin
            exp_tc = 0;
            exp_bin = (exp_bin + 1) % 16;
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick_en = 1'b1;
        @(negedge clk) tick_en = 1'b0;
        repeat (TICK_GAP - 2) @(negedge clk);
    endtask

    task automatic restart(input int hp);
        @(negedge clk) ctrl_en = 1'b0;
        half_period = 16'(hp);
        repeat (2) @(negedge clk);
        ctrl_en = 1'b1;
        model_hp = (hp < 8) ? 8 : hp;
        exp_bin = 0;
        exp_tc = 0;
    endtask

    function automatic int srcv(input int s, input int k);
        case (s)
            0: return 1000 + 37 * k;
            1: return -3000 + 113 * k;
            2: return 200 - 61 * k;
            default: return 30000 - 1499 * k;
        endcase
    endfunction

    // R1 R12: state straight after reset.
    task automatic t_reset();
        @(negedge clk);
        chk("R1 bin index", int'(bin_idx), 0);
        chk("R1 irq", int'(irq_pulse), 0);
        chk("R4 wave at reset", int'(wave_out), 0);
        chk("R1 bank entry 0", int'(smp_bank[15:0]), 0);
        chk("R12 bank entry 15", int'(smp_bank[255:240]), 0);
    endtask

    // R2/R3/R4: bin walk over two full periods.
    task automatic t_bin_walk(input int hp, input string tag);
        restart(hp);
        for (int k = 0; k < 4 * model_hp; k++) begin
            do_tick();
            model_tick();
            chk(tag, int'(bin_idx), exp_bin);
            chk("R4 wave level", int'(wave_out), (exp_bin >= 8) ? 1 : 0);
        end
    endtask

    // R4: polarity inversion acts at once.
    task automatic t_polarity();
        restart(8);
        repeat (3) do_tick();
        @(negedge clk) polarity = 1'b1;
        @(negedge clk);
        chk("R4 inverted first half", int'(wave_out), 1);
        repeat (6) do_tick();
        chk("R4 inverted second half", int'(wave_out), 0);
        @(negedge clk) polarity = 1'b0;
        @(negedge clk);
        chk("R4 normal second half", int'(wave_out), 1);
    endtask

    // R5/R6/R7: count interrupts over whole periods.
    task automatic t_irq(input int idx, input int div, input bit en, input int periods,
                         input int exp_cnt, input int exp_after, input string tag);
        irq_idx = 4'(idx);
        irq_div = 4'(div);
        irq_en = en;
        restart(8);
        irq_cnt = 0;
        last_irq_bin = -1;
        for (int k = 0; k < periods * 16; k++) do_tick();
        chk(tag, irq_cnt, exp_cnt);
        if (exp_cnt > 0) chk("R5 bin after pulse", last_irq_bin, exp_after);
    endtask

    // R8: disable holds bin 0, ignores ticks and restarts the divider.
    task automatic t_disable();
        restart(8);
        repeat (5) do_tick();
        chk("R8 before disable", int'(bin_idx), 5);
        @(negedge clk) ctrl_en = 1'b0;
        repeat (3) do_tick();
        chk("R8 bin held at zero", int'(bin_idx), 0);
        chk("R8 wave while off", int'(wave_out), 0);
        irq_idx = 4'd12;
        irq_div = 4'd3;
        irq_en = 1'b1;
        restart(8);
        irq_cnt = 0;
        repeat (16) do_tick();
        chk("R6 first period fires", irq_cnt, 1);
        repeat (4) do_tick();
        restart(8);
        irq_cnt = 0;
        repeat (16) do_tick();
        chk("R8 divider restarts on enable", irq_cnt, 1);
        irq_en = 1'b0;
    endtask

    // R9/R10/R11/R12: one full period of captures, all entries checked.
    task automatic t_samples(input int sel, input int mode, input int hp, input string tag);
        int exp_bank[16];
        int sum;
        int cnt;
        int last;
        int b;
        int v;
        smp_sel = 2'(sel);
        smp_mode = mode[0];
        restart(hp);
        sum = 0;
        cnt = 0;
        last = 0;
        for (int k = 0; k < 2 * model_hp; k++) begin
            @(negedge clk);
            src_sense = 16'(srcv(0, k));
            src_error = 16'(srcv(1, k));
            src_duty_flt = 16'(srcv(2, k));
            src_duty_ref = 16'(srcv(3, k));
            v = srcv(sel, k);
            sum += v;
            cnt++;
            last = v;
            b = exp_bin;
            do_tick();
            model_tick();
            if (exp_tc == 0) begin
                exp_bank[b] = (mode == 1) ? last : sum / cnt;
                sum = 0;
                cnt = 0;
            end
        end
        for (int e = 0; e < 16; e++)
            chk(tag, int'($signed(smp_bank[e*16 +: 16])), exp_bank[e]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bin_walk(20, "R2 bin index hp20");
        t_bin_walk(3, "R3 bin index short hp");
        t_polarity();
        t_irq(3, 0, 1'b1, 2, 4, 12, "R5 low index both halves");
        t_irq(12, 1, 1'b1, 2, 2, 13, "R5 high index second half");
        t_irq(15, 0, 1'b1, 1, 1, 0, "R5 last bin");
        t_irq(12, 3, 1'b1, 6, 2, 13, "R6 divide by three");
        t_irq(5, 2, 1'b1, 4, 4, 14, "R6 divide by two");
        t_irq(3, 0, 1'b0, 2, 0, 0, "R7 enable low");
        t_disable();
        t_samples(1, 0, 20, "R11 average error hp20");
        t_samples(0, 1, 8, "R10 last sense");
        t_samples(2, 1, 20, "R10 last filtered duty");
        t_samples(3, 0, 20, "R9 average duty ref");
        t_samples(2, 0, 12, "R9 average filtered duty hp12");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule